// File: doc/BRIEF.md
# Pre-Encoded Transmit Path with Sync Fill

This block sits at the transmit side of a serial link when the line encoder is bypassed. The host already holds encoded characters. It writes them into a small synchronous FIFO, one character per clock while its active-low write strobe is low. No code conversion is applied on the way in or out. The characters are 10 bits wide, or 12 bits in wide mode. In wide mode the two top bits are the two spare control inputs, carried as ordinary data.

A downstream serializer asks for one parallel character per character slot by pulsing `rd_slot`. If the FIFO holds a character, that character is presented with `out_valid` high. If the FIFO is empty, a sync filler is presented instead with `out_valid` low, so the character stream never stalls.

In narrow mode the filler is the comma character K28.5. Its two disparity forms alternate from one insertion to the next. In wide mode the filler is a fixed 12-bit sync word. Writes that arrive while the FIFO is full are discarded and set a sticky overflow flag.

Top module: `tx_prenc_fill`

## Requirements
- R1: Characters written to the FIFO come out on `out_char` unmodified and in write order, each with `out_valid` = 1.
- R2: A character is stored only on a rising clock edge where `wr_n` = 0. With `wr_n` = 1 the value on `wr_data` is not stored.
- R3: In narrow mode (`wide_mode` = 0), a read slot that finds the FIFO empty outputs K28.5 with `out_valid` = 0 and bits 11:10 = 0. The first insertion after reset is the negative form 10'b0011111010 (12'h0FA). Each later narrow insertion flips to the other form, whose positive form is 10'b1100000101 (12'h305).
- R4: In wide mode, a read slot that finds the FIFO empty outputs the fixed sync word 12'h611 with `out_valid` = 0. Wide insertions leave the K28.5 disparity state unchanged.
- R5: In narrow mode, bits 11:10 of `wr_data` are ignored. The stored character has them as 0.
- R6: A write while DEPTH characters are held is dropped and sets `overflow` to 1. `overflow` then stays 1 until reset.
- R7: `out_char` and `out_valid` change only on the clock edge after a cycle with `rd_slot` = 1. Otherwise they hold their values.
- R8: A synchronous active-high `rst` empties the FIFO and clears `out_char`, `out_valid` and `overflow`. It also returns the filler to the negative K28.5 form.
- R9: In wide mode, all 12 bits of `wr_data`, including the two top control bits, pass through unchanged.
- R10: The empty test for a read slot uses the FIFO contents from before that cycle's write. A character written in the same cycle as a read slot that finds the FIFO empty therefore appears at the next slot, after one filler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for write and read sides |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects 12-bit characters, 0 selects 10-bit |
| wr_n | input | 1 | Active-low write strobe |
| wr_data | input | 12 | Pre-encoded input character |
| rd_slot | input | 1 | Character-slot request from the serializer |
| out_char | output | 12 | Character delivered to the serializer |
| out_valid | output | 1 | 1 for FIFO data, 0 for an inserted filler |
| overflow | output | 1 | Sticky flag for a write dropped while full |

## Verification
The bench builds the block with DEPTH = 4, so a burst of six writes is enough to reach the full state. That brings the dropped-write path, the sticky flag and the boundary between the last stored character and the first filler within a short run. Long runs of empty slots in both modes test the K28.5 alternation and show that wide-mode fillers leave it alone. A write issued together with a slot on an empty FIFO shows the order between filler and data.

// File: rtl/tx_prenc_fill.sv
module tx_prenc_fill #(
  parameter int DEPTH = 16,
  parameter logic [11:0] SYNC_WIDE = 12'h611
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wide_mode,
  input  logic        wr_n,
  input  logic [11:0] wr_data,
  input  logic        rd_slot,
  output logic [11:0] out_char,
  output logic        out_valid,
  output logic        overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [9:0] K_NEG = 10'b0011111010;
  localparam logic [9:0] K_POS = 10'b1100000101;

  logic [11:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          disp_pos;

  wire full   = (count == CW'(DEPTH));
  wire empty  = (count == '0);
  wire do_wr  = !wr_n && !full;
  wire do_rd  = rd_slot && !empty;
  wire [11:0] wr_char = wide_mode ? wr_data : {2'b00, wr_data[9:0]};
  wire [11:0] fill    = wide_mode ? SYNC_WIDE : {2'b00, disp_pos ? K_POS : K_NEG};

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (do_wr) mem[wp] <= wr_char;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
      disp_pos <= 1'b0;
      out_char <= '0;
      out_valid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      if (do_wr && !do_rd) count <= count + 1'b1;
      else if (!do_wr && do_rd) count <= count - 1'b1;
      if (!wr_n && full) overflow <= 1'b1;
      if (rd_slot) begin
        out_valid <= !empty;
        out_char  <= empty ? fill : mem[rp];
        if (empty && !wide_mode) disp_pos <= !disp_pos;
      end
    end
  end
endmodule

module tx_prenc_fill_chk #(
  parameter int DEPTH = 16,
  parameter logic [11:0] SYNC_WIDE = 12'h611
) (
  input logic        clk,
  input logic        rst,
  input logic        wide_mode,
  input logic        wr_n,
  input logic        rd_slot,
  input logic [11:0] out_char,
  input logic        out_valid,
  input logic        overflow,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CW = $clog2(DEPTH + 1);

  AST_NARROW_FILL: assert property (@(posedge clk) disable iff (rst)
    rd_slot && count == '0 && !wide_mode |=> !out_valid && (out_char == 12'h0FA || out_char == 12'h305)); // R3
  AST_WIDE_FILL: assert property (@(posedge clk) disable iff (rst)
    rd_slot && count == '0 && wide_mode |=> !out_valid && out_char == SYNC_WIDE); // R4
  AST_DATA_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_slot && count != '0 |=> out_valid); // R1
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !rd_slot |=> $stable(out_char) && $stable(out_valid)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !overflow && !(!wr_n && count == CW'(DEPTH)) |=> !overflow); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid && !overflow && out_char == '0 && count == '0); // R8
endmodule

bind tx_prenc_fill tx_prenc_fill_chk #(.DEPTH(DEPTH), .SYNC_WIDE(SYNC_WIDE)) u_chk (
  .clk(clk), .rst(rst), .wide_mode(wide_mode), .wr_n(wr_n), .rd_slot(rd_slot),
  .out_char(out_char), .out_valid(out_valid), .overflow(overflow), .count(count)
);

// File: tb/sim_tx_prenc_fill.sv
`timescale 1ns/1ps
module sim_tx_prenc_fill;
  localparam int DEPTH = 4;
  logic clk = 0, rst = 1, wide_mode = 0, wr_n = 1, rd_slot = 0;
  logic [11:0] wr_data = '0;
  logic [11:0] out_char;
  logic out_valid, overflow;
  int checks = 0, failures = 0;

  typedef struct { logic [11:0] c; logic v; string tag; } item_t;
  item_t exp_q[$];
  logic [11:0] mq[$];
  logic disp = 0, ovf_exp = 0;

  tx_prenc_fill #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .wr_n(wr_n), .wr_data(wr_data),
    .rd_slot(rd_slot), .out_char(out_char), .out_valid(out_valid), .overflow(overflow));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; expected results go to the scoreboard
  task automatic cyc(input bit w, input logic [11:0] d, input bit r, input string tag);
    item_t it;
    bit full_before = (mq.size() == DEPTH);
    wr_n = !w; wr_data = d; rd_slot = r;
    if (r) begin
      if (mq.size() > 0) begin
        it.c = mq.pop_front(); it.v = 1;
      end else begin
        it.v = 0;
        if (wide_mode) it.c = 12'h611;
        else begin it.c = disp ? 12'h305 : 12'h0FA; disp = !disp; end
      end
      it.tag = tag;
      exp_q.push_back(it);
    end
    if (w) begin
      if (full_before) ovf_exp = 1;
      else mq.push_back(wide_mode ? d : {2'b00, d[9:0]});
    end
    @(negedge clk);
    wr_n = 1; rd_slot = 0;
  endtask

  task automatic do_reset();
    rst = 1; wr_n = 1; rd_slot = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    mq.delete(); disp = 0; ovf_exp = 0;
  endtask

  // monitor: compares after each edge
  initial begin
    logic [11:0] last_c = '0;
    logic last_v = 0;
    forever begin
      bit p, in_rst;
      @(posedge clk);
      p = rd_slot; in_rst = rst;
      @(negedge clk);
      if (in_rst) begin last_c = '0; last_v = 0; end
      else if (p) begin
        item_t it;
        if (exp_q.size() == 0) chk(0, "scoreboard empty", 13'h0, 13'h0);
        else begin
          it = exp_q.pop_front();
          chk(out_char == it.c && out_valid == it.v, it.tag, {out_valid, out_char}, {it.v, it.c});
        end
        last_c = out_char; last_v = out_valid;
      end else
        chk(out_char == last_c && out_valid == last_v, "R7 hold", {out_valid, out_char}, {last_v, last_c});
    end
  end

  initial begin
    #(8 * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(out_char == 0 && out_valid == 0 && overflow == 0, "R8 reset state", {out_valid, out_char}, 13'h0);
    // R3 alternating commas
    cyc(0, 0, 1, "R3 first fill negative");
    cyc(0, 0, 1, "R3 second fill positive");
    cyc(0, 0, 1, "R3 third fill negative");
    // R1 R5 narrow data with top bits set
    cyc(1, 12'hF23, 0, "");
    cyc(1, 12'hC7A, 0, "");
    cyc(1, 12'h3FF, 0, "");
    cyc(0, 0, 1, "R1 R5 data 0");
    cyc(0, 0, 1, "R1 R5 data 1");
    cyc(0, 0, 1, "R1 R5 data 2");
    // R2 write strobe high: nothing stored
    cyc(0, 12'h155, 0, "");
    cyc(0, 0, 1, "R2 no store, fill");
    // R4 wide fill, disparity untouched
    wide_mode = 1;
    cyc(0, 0, 1, "R4 wide fill");
    cyc(0, 0, 1, "R4 wide fill again");
    cyc(1, 12'hABC, 0, "");
    cyc(0, 0, 1, "R9 wide data top bits");
    wide_mode = 0;
    cyc(0, 0, 1, "R4 narrow resumes disparity");
    // R10 write together with slot on empty FIFO
    cyc(1, 12'h2AA, 1, "R10 fill before data");
    cyc(0, 0, 1, "R10 data next slot");
    // R6 overflow
    for (int i = 0; i < 6; i++) cyc(1, 12'h010 + 12'(i), 0, "");
    chk(overflow == 1, "R6 overflow set", {12'h0, overflow}, 13'h1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, "R6 kept data then fill");
    cyc(0, 0, 0, "");
    chk(overflow == 1, "R6 overflow sticky", {12'h0, overflow}, 13'h1);
    // R8 reset mid-stream
    cyc(1, 12'h0AB, 0, "");
    cyc(1, 12'h0CD, 0, "");
    do_reset();
    chk(overflow == 0 && out_valid == 0, "R8 flags cleared", {out_valid, 11'h0, overflow}, 13'h0);
    cyc(0, 0, 1, "R8 empty after reset, negative fill");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 13'(exp_q.size()), 13'h0);
    chk(overflow == ovf_exp, "R6 model agree", {12'h0, overflow}, {12'h0, ovf_exp});
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule